// File: doc/BRIEF.md
# Timing-Violation Capture and Sampling

This block is a cycle-level synchronous model of the error-detection logic behind a bank of transition-detecting latches. Each latch reports a transition pulse. Pulses are grouped into sticky flags, and a flag can be set only while a delayed copy of the stage's transparency signal (the arm signal) is high. The flags that belong to one sampler are ORed together. At the end of the resiliency window the sampler captures that OR on a separate sample strobe. It then reports the result as a dual-rail code, which stays 00 until a configurable settling latency has passed.

The results of several samplers are merged into one dual-rail pair. The violation rail rises if any sampler saw a violation. The clean rail rises only when every sampler reports no violation. Logic downstream must wait for one of the two rails and must not assume a fixed latency.

Each sampler is a four-state machine:
- SMP_IDLE: rails 00.
- SMP_SETTLE: rails 00, counting out the settling latency.
- SMP_HIT: violation rail high.
- SMP_CLEAN: clean rail high.

The transitions are:
- T_CAPTURE: SMP_IDLE goes to SMP_SETTLE on a rising strobe. If the settling latency is zero, it goes straight to SMP_HIT or SMP_CLEAN.
- T_RESOLVE: SMP_SETTLE goes to SMP_HIT or SMP_CLEAN when the count expires.
- T_ABORT: SMP_SETTLE goes to SMP_IDLE if the strobe falls early.
- T_RELEASE: SMP_HIT or SMP_CLEAN goes to SMP_IDLE when the strobe falls.

Top module: `tviol_capture`

## Requirements
- R1: A group flag becomes 1 at a clock edge where the arm signal is high and at least one of the group's GROUP_WIDTH (default 3) pulses is high.
- R2: A group flag becomes 0 at a clock edge where the arm signal is low, and it holds its value otherwise. A pulse while the arm signal is low has no effect.
- R3: Each sampler ORs GROUPS_PER_SMP (default 4) group flags, so any one of its 12 latches (pulse_i bits s*12 to s*12+11 for sampler s) can make it report a violation.
- R4: The arm signal is stage_open_i delayed by COMP_DELAY cycles (default 1). A pulse presented in the same cycle that stage_open_i first rises is not flagged.
- R5: A sampler captures the ORed flag value present at the clock edge where sample_i is first seen high. While sample_i stays high, it does not capture again and its rails stay stable.
- R6: The rail encoding {viol_o, clean_o} is 10 for a violation, 01 for no violation and 00 for unresolved. 11 never occurs.
- R7: The rails stay 00 after the capture edge and after each of the following SETTLE_CYCLES-1 edges (default 2). The result appears after capture edge + SETTLE_CYCLES.
- R8: After the first edge that sees sample_i low, both rails are 00.
- R9: viol_o is 1 if any sampler resolved with a violation. clean_o is 1 only if every sampler resolved clean.
- R10: A flag set in one window never appears in the result of the next window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stage_open_i | input | 1 | Stage transparency level (the resiliency window) |
| sample_i | input | 1 | Sample strobe; its rising edge ends the window |
| pulse_i | input | NUM_LATCHES | Transition pulses, one per latch |
| viol_o | output | 1 | Violation rail (Err[1]) |
| clean_o | output | 1 | No-violation rail (Err[0]) |

## Verification
Two functions can fall in the same clock edge: the capture of the ORed flags and the clearing of a flag. The bench provokes this in every window. It drops stage_open_i in the same cycle that it raises sample_i, so the flag clears just after the edge at which the sampler reads it. The bench judges the collision two ways. The window must still report its pulse as a violation. The following pulse-free window must resolve clean, which shows the clear did take effect.

// File: rtl/tviol_pkg.sv
package tviol_pkg;
    typedef enum logic [1:0] {
        SMP_IDLE   = 2'd0,
        SMP_SETTLE = 2'd1,
        SMP_HIT    = 2'd2,
        SMP_CLEAN  = 2'd3
    } smp_state_t;
endpackage

// File: rtl/tviol_arm_delay.sv
module tviol_arm_delay #(
    parameter int COMP_DELAY = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stage_open_i,
    output logic arm_o
);
    generate
        if (COMP_DELAY == 0) begin : g_direct
            assign arm_o = stage_open_i;
        end else begin : g_chain
            logic [COMP_DELAY-1:0] chain_q;
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q[0] <= 1'b0;
                else        chain_q[0] <= stage_open_i;
            end
            for (genvar i = 1; i < COMP_DELAY; i++) begin : g_tap
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[i] <= 1'b0;
                    else        chain_q[i] <= chain_q[i-1];
                end
            end
            assign arm_o = chain_q[COMP_DELAY-1];

            if (COMP_DELAY == 1) begin : g_chk
                // R4: the arm signal is still low in the cycle the transparency rises
                a_r4_comp_lag: assert property (@(posedge clk) disable iff (!rst_n)
                    $rose(stage_open_i) |-> !arm_o);
            end
        end
    endgenerate
endmodule

// File: rtl/tviol_group_flag.sv
module tviol_group_flag #(
    parameter int GROUP_WIDTH = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   arm_i,
    input  logic [GROUP_WIDTH-1:0] pulse_i,
    output logic                   flag_o
);
    logic any_pulse;
    assign any_pulse = |pulse_i;

    always_ff @(posedge clk) begin
        if (!rst_n)                  flag_o <= 1'b0;
        else if (arm_i && any_pulse) flag_o <= 1'b1;
        else if (!arm_i)             flag_o <= 1'b0;
    end

    a_r1_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_i && any_pulse) |=> flag_o);

    a_r2_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !arm_i |=> !flag_o);
endmodule

// File: rtl/tviol_sampler.sv
module tviol_sampler
    import tviol_pkg::*;
#(
    parameter int SETTLE_CYCLES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sample_i,
    input  logic flags_or_i,
    output logic viol_o,
    output logic clean_o
);
    localparam int CW = (SETTLE_CYCLES > 1) ? $clog2(SETTLE_CYCLES) : 1;

    smp_state_t    state_q, state_d;
    logic          sample_q;
    logic          seen_q;
    logic [CW-1:0] cnt_q;
    logic          start;
    logic          cnt_done;

    assign start    = sample_i && !sample_q;
    assign cnt_done = (int'(cnt_q) >= SETTLE_CYCLES - 1);

    // state register and companions
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= SMP_IDLE;
            sample_q <= 1'b0;
            seen_q   <= 1'b0;
            cnt_q    <= '0;
        end else begin
            state_q  <= state_d;
            sample_q <= sample_i;
            if (state_q == SMP_IDLE && start) seen_q <= flags_or_i;
            if (state_q == SMP_SETTLE) cnt_q <= cnt_q + 1'b1;
            else                       cnt_q <= '0;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SMP_IDLE: begin
                if (start) begin
                    if (SETTLE_CYCLES == 0) state_d = flags_or_i ? SMP_HIT : SMP_CLEAN;
                    else                    state_d = SMP_SETTLE;
                end
            end
            SMP_SETTLE: begin
                if (!sample_i)     state_d = SMP_IDLE;
                else if (cnt_done) state_d = seen_q ? SMP_HIT : SMP_CLEAN;
            end
            SMP_HIT, SMP_CLEAN: begin
                if (!sample_i) state_d = SMP_IDLE;
            end
            default: state_d = SMP_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        viol_o  = 1'b0;
        clean_o = 1'b0;
        unique case (state_q)
            SMP_HIT:   viol_o  = 1'b1;
            SMP_CLEAN: clean_o = 1'b1;
            default: ;
        endcase
    end

    a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_i |=> (!viol_o && !clean_o));

    a_r5_hold_result: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_i && (viol_o || clean_o)) |=> ($stable(viol_o) && $stable(clean_o)));

    generate
        if (SETTLE_CYCLES > 0) begin : g_settle_chk
            a_r7_unresolved: assert property (@(posedge clk) disable iff (!rst_n)
                (start && state_q == SMP_IDLE) |=> (!viol_o && !clean_o));
        end
    endgenerate
endmodule

// File: rtl/tviol_rail_merge.sv
module tviol_rail_merge #(
    parameter int NUM_SMP = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SMP-1:0] viol_i,
    input  logic [NUM_SMP-1:0] clean_i,
    output logic               viol_o,
    output logic               clean_o
);
    assign viol_o  = |viol_i;
    assign clean_o = &clean_i;

    a_r6_never_both: assert property (@(posedge clk) disable iff (!rst_n)
        !(viol_o && clean_o));

    a_r9_merge_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({viol_o, clean_o}));
endmodule

// File: rtl/tviol_capture.sv
module tviol_capture #(
    parameter int GROUP_WIDTH    = 3,
    parameter int GROUPS_PER_SMP = 4,
    parameter int NUM_SMP        = 2,
    parameter int COMP_DELAY     = 1,
    parameter int SETTLE_CYCLES  = 2,
    localparam int LATCHES_PER_SMP = GROUP_WIDTH * GROUPS_PER_SMP,
    localparam int NUM_LATCHES     = LATCHES_PER_SMP * NUM_SMP
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   stage_open_i,
    input  logic                   sample_i,
    input  logic [NUM_LATCHES-1:0] pulse_i,
    output logic                   viol_o,
    output logic                   clean_o
);
    localparam int NUM_GROUPS = GROUPS_PER_SMP * NUM_SMP;

    logic                  arm;
    logic [NUM_GROUPS-1:0] flags;
    logic [NUM_SMP-1:0]    smp_viol;
    logic [NUM_SMP-1:0]    smp_clean;

    tviol_arm_delay #(.COMP_DELAY(COMP_DELAY)) u_arm (
        .clk          (clk),
        .rst_n        (rst_n),
        .stage_open_i (stage_open_i),
        .arm_o        (arm)
    );

    generate
        for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
            tviol_group_flag #(.GROUP_WIDTH(GROUP_WIDTH)) u_flag (
                .clk     (clk),
                .rst_n   (rst_n),
                .arm_i   (arm),
                .pulse_i (pulse_i[g*GROUP_WIDTH +: GROUP_WIDTH]),
                .flag_o  (flags[g])
            );
        end
        for (genvar s = 0; s < NUM_SMP; s++) begin : g_smp
            tviol_sampler #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_smp (
                .clk        (clk),
                .rst_n      (rst_n),
                .sample_i   (sample_i),
                .flags_or_i (|flags[s*GROUPS_PER_SMP +: GROUPS_PER_SMP]),
                .viol_o     (smp_viol[s]),
                .clean_o    (smp_clean[s])
            );
        end
    endgenerate

    tviol_rail_merge #(.NUM_SMP(NUM_SMP)) u_merge (
        .clk     (clk),
        .rst_n   (rst_n),
        .viol_i  (smp_viol),
        .clean_i (smp_clean),
        .viol_o  (viol_o),
        .clean_o (clean_o)
    );
endmodule

// File: tb/tviol_capture_tb.sv
module tviol_capture_tb;
    localparam int SETTLE = 2;
    localparam int NLAT   = 24;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            stage_open = 1'b0;
    logic            sample = 1'b0;
    logic [NLAT-1:0] pulse = '0;
    logic            viol, clean;

    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;

    always #5 clk = ~clk;

    tviol_capture #(.SETTLE_CYCLES(SETTLE)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .stage_open_i (stage_open),
        .sample_i     (sample),
        .pulse_i      (pulse),
        .viol_o       (viol),
        .clean_o      (clean)
    );

    task automatic chk(input string req, input logic [1:0] exp);
        checks++;
        if ({viol, clean} !== exp) begin
            errors++;
            $display("FAIL %s: rails actual=%b expected=%b at %0t", req, {viol, clean}, exp, $time);
        end
    endtask

    // One window. `lat` is the pulsed latch (-1 for none). With `early` set, the
    // pulse is presented together with the rising transparency (R4 case).
    task automatic run_window(input int lat, input bit early, input logic [1:0] exp, input string req);
        @(negedge clk);
        stage_open = 1'b1;
        if (lat >= 0 && early) pulse[lat] = 1'b1;
        @(negedge clk);
        pulse = '0;
        if (lat >= 0 && !early) pulse[lat] = 1'b1;
        @(negedge clk);
        pulse = '0;
        // capture and flag clear collide here: close the window and raise the strobe together
        @(negedge clk);
        stage_open = 1'b0;
        sample = 1'b1;
        @(negedge clk);
        for (int i = 0; i < SETTLE; i++) begin
            chk({req, " R7 unresolved"}, 2'b00);
            @(negedge clk);
        end
        chk(req, exp);
        @(negedge clk);
        chk({req, " R5 held strobe"}, exp);
        sample = 1'b0;
        @(negedge clk);
        chk({req, " R8 release"}, 2'b00);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk("R6 reset rails", 2'b00);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R6 idle after reset", 2'b00);
    endtask

    task automatic t_member_hits();
        run_window(0,  1'b0, 2'b10, "R1 latch0 hit");
        run_window(13, 1'b0, 2'b10, "R3 latch13 hit");
        run_window(23, 1'b0, 2'b10, "R9 sampler1 only hit");
    endtask

    task automatic t_clean();
        run_window(-1, 1'b0, 2'b01, "R9 all clean");
    endtask

    task automatic t_comp_delay();
        run_window(5, 1'b1, 2'b01, "R4 pulse at rising edge ignored");
    endtask

    task automatic t_low_pulse();
        @(negedge clk);
        pulse[7] = 1'b1;
        @(negedge clk);
        pulse = '0;
        pulse[20] = 1'b1;
        @(negedge clk);
        pulse = '0;
        run_window(-1, 1'b0, 2'b01, "R2 pulse while closed ignored");
    endtask

    task automatic t_no_leak();
        run_window(10, 1'b0, 2'b10, "R10 first window hit");
        run_window(-1, 1'b0, 2'b01, "R10 next window clean");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_member_hits();
        t_clean();
        t_comp_delay();
        t_low_pulse();
        t_no_leak();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule